// File: doc/BRIEF.md
# Floating-Point Compare Condition Evaluator

This block evaluates one floating-point comparison predicate per strobe. Two operands arrive together with a format select (single or double precision), a magnitude-only option, a 4-bit predicate mask and the index of the condition-code bit that receives the outcome. The block decides whether the operands are unordered, equal or ordered-less, combines those three relations through the mask, and reports whether the comparison is an invalid operation.

Its results leave in a fixed order. One cycle after the strobe, a status pulse carries the invalid-operation flag and the predicate outcome, so the control register can take the exception status first. One cycle later, a one-hot write enable selects the addressed condition-code bit, and the outcome is written into it. Strobes may arrive on back-to-back cycles.

Top module: `fcmp_eval`

## Requirements
- R1: `stat_vld_o` is high exactly in the cycle after a cycle with `in_vld_i` high. In cycles where it is low, `stat_inv_o` and `cmp_res_o` are low too.
- R2: If either operand is a NaN (exponent all ones, nonzero fraction), the relation is unordered, and both less and equal are false.
- R3: When an operand is a NaN, `stat_inv_o` is raised if mask bit 3 is set or if either operand is a signalling NaN. A NaN is signalling when its fraction MSB is 1. A quiet NaN with mask bit 3 clear raises nothing.
- R4: When neither operand is a NaN, `stat_inv_o` stays low whatever the mask.
- R5: The outcome is (mask[2] AND less) OR (mask[1] AND equal) OR (mask[0] AND unordered). A mask with bits 2..0 all zero gives 0.
- R6: Ordered operands compare by numeric value, negatives included, and less is false whenever equal is true. +0 and -0 are equal, and operands with identical bits that are not NaN are equal.
- R7: With `mag_only_i` high, both sign bits are ignored, so operands that differ only in sign compare equal.
- R8: With `fmt_dbl_i` low, each operand is a single-precision value in bits 31..0 and bits 63..32 have no effect. With `fmt_dbl_i` high, all 64 bits form a double-precision value.
- R9: One cycle after `stat_vld_o`, `cc_we_o` is one-hot at the index sampled with the strobe and `cc_val_o` equals the `cmp_res_o` of the previous cycle. At all other times `cc_we_o` is zero.
- R10: While reset is asserted, `stat_vld_o`, `stat_inv_o`, `cmp_res_o`, `cc_we_o` and `cc_val_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 1 | Comparison strobe |
| fmt_dbl_i | input | 1 | 1 = double precision, 0 = single precision in bits 31..0 |
| mag_only_i | input | 1 | Compare magnitudes only |
| cond_i | input | 4 | Predicate mask: [3] signal on any NaN, [2] less, [1] equal, [0] unordered |
| cc_sel_i | input | SEL_W (3) | Condition-code bit index |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| stat_vld_o | output | 1 | Status and outcome valid (done pulse) |
| stat_inv_o | output | 1 | Invalid-operation status |
| cmp_res_o | output | 1 | Predicate outcome |
| cc_we_o | output | CC_NUM (8) | One-hot condition-code write enable |
| cc_val_o | output | 1 | Value written to the selected condition-code bit |

## Verification
The bench builds the block with its default widths: eight condition-code bits, and the standard 8/23 and 11/52 exponent/fraction splits. This makes every condition-code index from 0 to 7 reachable, and both formats can be exercised with hand-encoded values such as ±1.0, ±0, infinity and quiet and signalling NaNs. Its reference model maps each ordered operand to a signed integer key instead of walking sign cases. This gives an independent view of negative ordering and of the ±0 equality. Single-precision stimulus carries arbitrary upper halves, and double stimulus differs only in its upper half. These cases show that the format select picks the right bits.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    // Widest magnitude (exponent + fraction) that any supported format uses.
    localparam int MAG_W = 63;

    // Per-operand classification handed from the classifiers to the ordering logic.
    typedef struct packed {
        logic             sgn;   // sign after the magnitude-only option
        logic             nan;   // exponent all ones, fraction nonzero
        logic             sig;   // signalling NaN (fraction MSB set)
        logic             zro;   // +0 or -0
        logic [MAG_W-1:0] mag;   // exponent and fraction, zero-extended
    } opnd_t;

    // Relation between the two operands.
    typedef struct packed {
        logic lt;
        logic eq;
        logic un;
    } rel_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] raw_i,
    input  logic                  mag_only_i,
    output opnd_t                 info_o
);

    localparam int TOP = EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_w;
    logic [FRAC_W-1:0] frac_w;
    logic              exp_max_w;
    logic              frac_nz_w;

    assign exp_w     = raw_i[TOP-1:FRAC_W];
    assign frac_w    = raw_i[FRAC_W-1:0];
    assign exp_max_w = &exp_w;
    assign frac_nz_w = |frac_w;

    always_comb begin
        info_o     = '0;
        info_o.sgn = raw_i[TOP] & ~mag_only_i;
        info_o.nan = exp_max_w & frac_nz_w;
        info_o.sig = exp_max_w & frac_nz_w & frac_w[FRAC_W-1];
        info_o.zro = ~(|raw_i[TOP-1:0]);
        info_o.mag = MAG_W'(raw_i[TOP-1:0]);
    end

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
(
    input  opnd_t a_i,
    input  opnd_t b_i,
    output rel_t  rel_o
);

    always_comb begin
        rel_o = '0;
        if (a_i.nan || b_i.nan) begin
            rel_o.un = 1'b1;
        end else if (a_i.zro && b_i.zro) begin
            // signed zeros are the same value
            rel_o.eq = 1'b1;
        end else if (a_i.sgn != b_i.sgn) begin
            // opposite signs, at least one nonzero: negative side is smaller
            rel_o.lt = a_i.sgn;
        end else begin
            rel_o.eq = (a_i.mag == b_i.mag);
            if (a_i.sgn) begin
                rel_o.lt = (a_i.mag > b_i.mag);
            end else begin
                rel_o.lt = (a_i.mag < b_i.mag);
            end
        end
    end

endmodule

// File: rtl/fcmp_pred.sv
module fcmp_pred
    import fcmp_pkg::*;
(
    input  rel_t       rel_i,
    input  logic [3:0] cond_i,
    input  logic       any_sig_i,
    output logic       res_o,
    output logic       inv_o
);

    always_comb begin
        res_o = (cond_i[2] & rel_i.lt) | (cond_i[1] & rel_i.eq) | (cond_i[0] & rel_i.un);
        inv_o = rel_i.un & (cond_i[3] | any_sig_i);
    end

endmodule

// File: rtl/fcmp_eval.sv
module fcmp_eval
    import fcmp_pkg::*;
#(
    parameter int CC_NUM    = 8,
    parameter int SEL_W     = $clog2(CC_NUM),
    parameter int SP_EXP_W  = 8,
    parameter int SP_FRAC_W = 23,
    parameter int DP_EXP_W  = 11,
    parameter int DP_FRAC_W = 52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld_i,
    input  logic              fmt_dbl_i,
    input  logic              mag_only_i,
    input  logic [3:0]        cond_i,
    input  logic [SEL_W-1:0]  cc_sel_i,
    input  logic [63:0]       opa_i,
    input  logic [63:0]       opb_i,
    output logic              stat_vld_o,
    output logic              stat_inv_o,
    output logic              cmp_res_o,
    output logic [CC_NUM-1:0] cc_we_o,
    output logic              cc_val_o
);

    localparam int SP_W = SP_EXP_W + SP_FRAC_W + 1;
    localparam int DP_W = DP_EXP_W + DP_FRAC_W + 1;

    // stage 1: status and outcome; stage 2: condition-code write
    typedef struct packed {
        logic              s1_vld;
        logic              s1_inv;
        logic              s1_res;
        logic [SEL_W-1:0]  s1_sel;
        logic [CC_NUM-1:0] s2_we;
        logic              s2_val;
    } st_t;

    st_t st_d, st_q;

    logic [1:0][63:0] raw_w;
    opnd_t            sp_info_w [2];
    opnd_t            dp_info_w [2];
    opnd_t            sel_info_w [2];
    rel_t             rel_w;
    logic             res_w;
    logic             inv_w;
    logic             any_sig_w;

    assign raw_w = {opb_i, opa_i};

    for (genvar g = 0; g < 2; g++) begin : g_opnd
        fcmp_classify #(
            .EXP_W  (SP_EXP_W),
            .FRAC_W (SP_FRAC_W)
        ) u_sp_cls (
            .raw_i      (raw_w[g][SP_W-1:0]),
            .mag_only_i (mag_only_i),
            .info_o     (sp_info_w[g])
        );

        fcmp_classify #(
            .EXP_W  (DP_EXP_W),
            .FRAC_W (DP_FRAC_W)
        ) u_dp_cls (
            .raw_i      (raw_w[g][DP_W-1:0]),
            .mag_only_i (mag_only_i),
            .info_o     (dp_info_w[g])
        );

        assign sel_info_w[g] = fmt_dbl_i ? dp_info_w[g] : sp_info_w[g];
    end

    assign any_sig_w = sel_info_w[0].sig | sel_info_w[1].sig;

    fcmp_order u_order (
        .a_i   (sel_info_w[0]),
        .b_i   (sel_info_w[1]),
        .rel_o (rel_w)
    );

    fcmp_pred u_pred (
        .rel_i     (rel_w),
        .cond_i    (cond_i),
        .any_sig_i (any_sig_w),
        .res_o     (res_w),
        .inv_o     (inv_w)
    );

    always_comb begin
        st_d        = st_q;
        st_d.s1_vld = in_vld_i;
        st_d.s1_inv = in_vld_i & inv_w;
        st_d.s1_res = in_vld_i & res_w;
        if (in_vld_i) begin
            st_d.s1_sel = cc_sel_i;
        end
        st_d.s2_we  = st_q.s1_vld ? (CC_NUM'(1) << st_q.s1_sel) : '0;
        st_d.s2_val = st_q.s1_vld & st_q.s1_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_vld_o = st_q.s1_vld;
    assign stat_inv_o = st_q.s1_inv;
    assign cmp_res_o  = st_q.s1_res;
    assign cc_we_o    = st_q.s2_we;
    assign cc_val_o   = st_q.s2_val;

endmodule

// File: rtl/fcmp_eval_chk.sv
module fcmp_eval_chk #(
    parameter int CC_NUM    = 8,
    parameter int SEL_W     = 3,
    parameter int SP_EXP_W  = 8,
    parameter int SP_FRAC_W = 23,
    parameter int DP_EXP_W  = 11,
    parameter int DP_FRAC_W = 52
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_vld_i,
    input logic              fmt_dbl_i,
    input logic              mag_only_i,
    input logic [3:0]        cond_i,
    input logic [SEL_W-1:0]  cc_sel_i,
    input logic [63:0]       opa_i,
    input logic [63:0]       opb_i,
    input logic              stat_vld_o,
    input logic              stat_inv_o,
    input logic              cmp_res_o,
    input logic [CC_NUM-1:0] cc_we_o,
    input logic              cc_val_o
);

    localparam int SPT = SP_EXP_W + SP_FRAC_W;
    localparam int DPT = DP_EXP_W + DP_FRAC_W;

    logic a_nan_w, b_nan_w, any_nan_w;
    logic [63:0] sign_flip_w;

    assign a_nan_w = fmt_dbl_i ? ((&opa_i[DPT-1:DP_FRAC_W]) && (|opa_i[DP_FRAC_W-1:0]))
                               : ((&opa_i[SPT-1:SP_FRAC_W]) && (|opa_i[SP_FRAC_W-1:0]));
    assign b_nan_w = fmt_dbl_i ? ((&opb_i[DPT-1:DP_FRAC_W]) && (|opb_i[DP_FRAC_W-1:0]))
                               : ((&opb_i[SPT-1:SP_FRAC_W]) && (|opb_i[SP_FRAC_W-1:0]));
    assign any_nan_w   = a_nan_w | b_nan_w;
    assign sign_flip_w = fmt_dbl_i ? (64'd1 << DPT) : (64'd1 << SPT);

    p_done_tracks_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld_i |=> stat_vld_o);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld_i |=> (!stat_vld_o && !stat_inv_o && !cmp_res_o));

    p_qnan_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && cond_i[3] && any_nan_w) |=> stat_inv_o);

    p_no_nan_no_inv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && !any_nan_w) |=> !stat_inv_o);

    p_empty_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && cond_i[2:0] == 3'b000) |=> !cmp_res_o);

    p_self_equal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && !a_nan_w && opa_i == opb_i && cond_i[2:0] == 3'b010) |=> cmp_res_o);

    p_sign_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && mag_only_i && !a_nan_w && opb_i == (opa_i ^ sign_flip_w)
         && cond_i[2:0] == 3'b010) |=> cmp_res_o);

    p_cc_after_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|cc_we_o) |-> $past(stat_vld_o));

    p_cc_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld_o |=> ($countones(cc_we_o) == 1 && cc_val_o == $past(cmp_res_o)));

    p_cc_index_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld_i |-> ##2 (cc_we_o == (CC_NUM'(1) << $past(cc_sel_i, 2))));

    p_cc_onehot0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cc_we_o));

endmodule

bind fcmp_eval fcmp_eval_chk #(
    .CC_NUM    (CC_NUM),
    .SEL_W     (SEL_W),
    .SP_EXP_W  (SP_EXP_W),
    .SP_FRAC_W (SP_FRAC_W),
    .DP_EXP_W  (DP_EXP_W),
    .DP_FRAC_W (DP_FRAC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_vld_i   (in_vld_i),
    .fmt_dbl_i  (fmt_dbl_i),
    .mag_only_i (mag_only_i),
    .cond_i     (cond_i),
    .cc_sel_i   (cc_sel_i),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .stat_vld_o (stat_vld_o),
    .stat_inv_o (stat_inv_o),
    .cmp_res_o  (cmp_res_o),
    .cc_we_o    (cc_we_o),
    .cc_val_o   (cc_val_o)
);

// File: tb/fcmp_eval_tb_top.sv
`timescale 1ns/1ps
module fcmp_eval_tb_top;

    localparam int CC_NUM = 8;
    localparam int SEL_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_vld_i = 1'b0;
    logic              fmt_dbl_i = 1'b0;
    logic              mag_only_i = 1'b0;
    logic [3:0]        cond_i = '0;
    logic [SEL_W-1:0]  cc_sel_i = '0;
    logic [63:0]       opa_i = '0;
    logic [63:0]       opb_i = '0;
    logic              stat_vld_o;
    logic              stat_inv_o;
    logic              cmp_res_o;
    logic [CC_NUM-1:0] cc_we_o;
    logic              cc_val_o;

    always #2 clk = ~clk;

    fcmp_eval #(.CC_NUM(CC_NUM)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_vld_i   (in_vld_i),
        .fmt_dbl_i  (fmt_dbl_i),
        .mag_only_i (mag_only_i),
        .cond_i     (cond_i),
        .cc_sel_i   (cc_sel_i),
        .opa_i      (opa_i),
        .opb_i      (opb_i),
        .stat_vld_o (stat_vld_o),
        .stat_inv_o (stat_inv_o),
        .cmp_res_o  (cmp_res_o),
        .cc_we_o    (cc_we_o),
        .cc_val_o   (cc_val_o)
    );

    typedef struct {
        logic             res;
        logic             inv;
        logic [SEL_W-1:0] sel;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Reference: ordered operands become signed integer keys.
    function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                  input logic dbl, input logic mo, input logic [3:0] c,
                                  output logic r, output logic inv);
        logic sa, sb, na, nb, qa, qb, un, lt, eq;
        logic [62:0] ma, mb;
        longint ka, kb;
        if (dbl) begin
            sa = a[63]; ma = a[62:0];
            sb = b[63]; mb = b[62:0];
            na = (a[62:52] == 11'h7FF) && (a[51:0] != 0); qa = na && a[51];
            nb = (b[62:52] == 11'h7FF) && (b[51:0] != 0); qb = nb && b[51];
        end else begin
            sa = a[31]; ma = {32'd0, a[30:0]};
            sb = b[31]; mb = {32'd0, b[30:0]};
            na = (a[30:23] == 8'hFF) && (a[22:0] != 0); qa = na && a[22];
            nb = (b[30:23] == 8'hFF) && (b[22:0] != 0); qb = nb && b[22];
        end
        if (mo) begin
            sa = 1'b0;
            sb = 1'b0;
        end
        ka = sa ? -$signed({1'b0, ma}) : $signed({1'b0, ma});
        kb = sb ? -$signed({1'b0, mb}) : $signed({1'b0, mb});
        un  = na | nb;
        lt  = !un && (ka < kb);
        eq  = !un && (ka == kb);
        r   = (c[2] & lt) | (c[1] & eq) | (c[0] & un);
        inv = un & (c[3] | qa | qb);
    endfunction

    task automatic send(input logic [63:0] a, input logic [63:0] b, input logic dbl,
                        input logic mo, input logic [3:0] c, input logic [SEL_W-1:0] sel,
                        input string tag, input logic exp_res, input logic exp_inv);
        exp_t e;
        logic mr, mi;
        model(a, b, dbl, mo, c, mr, mi);
        // hand-derived value cross-checks the reference model
        check(mr == exp_res && mi == exp_inv, tag, "model vs hand value",
              {mr, mi}, {exp_res, exp_inv});
        e.res = mr; e.inv = mi; e.sel = sel; e.tag = tag;
        exp_q.push_back(e);
        opa_i = a; opb_i = b; fmt_dbl_i = dbl; mag_only_i = mo;
        cond_i = c; cc_sel_i = sel; in_vld_i = 1'b1;
        @(negedge clk);
        in_vld_i = 1'b0;
    endtask

    // Monitor: compares outputs at falling edges.
    bit               cc_pend = 1'b0;
    logic [SEL_W-1:0] cc_pend_sel = '0;
    logic             cc_pend_val = 1'b0;
    string            cc_pend_tag = "";

    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (cc_pend) begin
                check(cc_we_o == (CC_NUM'(1) << cc_pend_sel), "R9", {cc_pend_tag, " cc_we"},
                      cc_we_o, CC_NUM'(1) << cc_pend_sel);
                check(cc_val_o == cc_pend_val, "R9", {cc_pend_tag, " cc_val"},
                      cc_val_o, cc_pend_val);
            end else if (cc_we_o != 0) begin
                check(1'b0, "R9", "stray cc write", cc_we_o, 0);
            end
            cc_pend = 1'b0;
            if (stat_vld_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1", "unexpected done pulse", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(cmp_res_o == e.res, e.tag, "result", cmp_res_o, e.res);
                    check(stat_inv_o == e.inv, e.tag, "invalid", stat_inv_o, e.inv);
                    cc_pend = 1'b1; cc_pend_sel = e.sel;
                    cc_pend_val = e.res; cc_pend_tag = e.tag;
                end
            end else begin
                check(!stat_inv_o && !cmp_res_o, "R1", "idle outputs",
                      {stat_inv_o, cmp_res_o}, 0);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        finish_run();
    end

    localparam logic [63:0] S1P  = 64'h3F80_0000;
    localparam logic [63:0] S2P  = 64'h4000_0000;
    localparam logic [63:0] S1N  = 64'hBF80_0000;
    localparam logic [63:0] S2N  = 64'hC000_0000;
    localparam logic [63:0] SZP  = 64'h0000_0000;
    localparam logic [63:0] SZN  = 64'h8000_0000;
    localparam logic [63:0] SINF = 64'h7F80_0000;
    localparam logic [63:0] SQN  = 64'h7FA0_0000;
    localparam logic [63:0] SSN  = 64'h7FC0_0000;
    localparam logic [63:0] D1P  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] D2P  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] D3N  = 64'hC008_0000_0000_0000;
    localparam logic [63:0] DQN  = 64'h7FF4_0000_0000_0000;
    localparam logic [63:0] DSN  = 64'h7FF8_0000_0000_0000;

    initial begin
        #1;
        // R10: outputs held at zero during reset
        repeat (3) @(negedge clk);
        check(!stat_vld_o && !stat_inv_o && !cmp_res_o && cc_we_o == 0 && !cc_val_o,
              "R10", "reset state", {stat_vld_o, stat_inv_o, cmp_res_o, cc_we_o, cc_val_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 R6: ordering, singles, back to back
        send(S1P, S2P, 1'b0, 1'b0, 4'b0100, 3'd0, "R6 1<2",   1'b1, 1'b0);
        send(S2P, S1P, 1'b0, 1'b0, 4'b0100, 3'd1, "R6 2<1",   1'b0, 1'b0);
        send(S2N, S1N, 1'b0, 1'b0, 4'b0100, 3'd2, "R6 -2<-1", 1'b1, 1'b0);
        send(S1N, S2N, 1'b0, 1'b0, 4'b0110, 3'd3, "R5 -1<=-2", 1'b0, 1'b0);
        send(SZP, SZN, 1'b0, 1'b0, 4'b0010, 3'd4, "R6 +0==-0", 1'b1, 1'b0);
        send(SZN, SZP, 1'b0, 1'b0, 4'b0100, 3'd5, "R6 -0<+0",  1'b0, 1'b0);
        send(S1N, S1P, 1'b0, 1'b0, 4'b0011, 3'd6, "R5 -1 le/un 1", 1'b0, 1'b0);
        repeat (2) @(negedge clk);

        // R7: magnitude only
        send(S1N, S1P, 1'b0, 1'b1, 4'b0010, 3'd7, "R7 |-1|==|1|", 1'b1, 1'b0);
        send(S2N, S1P, 1'b0, 1'b1, 4'b0100, 3'd0, "R7 |-2|<|1|",  1'b0, 1'b0);
        send(S2N, S1P, 1'b0, 1'b0, 4'b0100, 3'd1, "R7 signed -2<1", 1'b1, 1'b0);

        // R2 R3 R4: NaN handling
        send(SQN, S1P, 1'b0, 1'b0, 4'b0001, 3'd2, "R2 qnan unordered", 1'b1, 1'b0);
        send(SQN, SQN, 1'b0, 1'b0, 4'b0110, 3'd3, "R2 qnan not lt/eq", 1'b0, 1'b0);
        send(S1P, SQN, 1'b0, 1'b0, 4'b1001, 3'd4, "R3 bit3 signals",   1'b1, 1'b1);
        send(SSN, S1P, 1'b0, 1'b0, 4'b0001, 3'd5, "R3 snan signals",   1'b1, 1'b1);
        send(SINF, S1P, 1'b0, 1'b0, 4'b1110, 3'd6, "R4 inf no inv",    1'b0, 1'b0);
        send(SINF, SINF, 1'b0, 1'b0, 4'b1010, 3'd7, "R4 inf==inf",     1'b1, 1'b0);
        send(S1P, S2P, 1'b0, 1'b0, 4'b1000, 3'd0, "R5 empty mask",     1'b0, 1'b0);
        @(negedge clk);

        // R8: format select
        send({32'hDEAD_BEEF, S1P[31:0]}, {32'h1234_5678, S1P[31:0]}, 1'b0, 1'b0, 4'b0010,
             3'd1, "R8 single ignores upper", 1'b1, 1'b0);
        send({32'h7FFF_FFFF, S1P[31:0]}, S2P, 1'b0, 1'b0, 4'b0100,
             3'd2, "R8 upper nan ignored", 1'b1, 1'b0);
        send(D1P, D2P, 1'b1, 1'b0, 4'b0010, 3'd3, "R8 double upper used", 1'b0, 1'b0);
        send(D1P, D3N, 1'b1, 1'b0, 4'b0100, 3'd4, "R6 double 1<-3",  1'b0, 1'b0);
        send(D3N, D1P, 1'b1, 1'b0, 4'b0100, 3'd5, "R6 double -3<1",  1'b1, 1'b0);
        send(D3N, D1P, 1'b1, 1'b1, 4'b0100, 3'd6, "R7 double |-3|<1", 1'b0, 1'b0);
        send(DQN, D1P, 1'b1, 1'b0, 4'b1000, 3'd7, "R3 double qnan bit3", 1'b0, 1'b1);
        send(DQN, D1P, 1'b1, 1'b0, 4'b0111, 3'd0, "R3 double qnan quiet", 1'b1, 1'b0);
        send(D1P, DSN, 1'b1, 1'b0, 4'b0001, 3'd1, "R3 double snan", 1'b1, 1'b1);
        send(D1P, D1P, 1'b1, 1'b0, 4'b0010, 3'd2, "R6 double equal", 1'b1, 1'b0);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R1", "all results seen", exp_q.size(), 0);
        finish_run();
    end

endmodule